// File: doc/BRIEF.md
# Single-Lane Serial Transaction Master

This block runs one complete master-side transaction on a four-wire serial bus used in single-lane mode. Data leaves the master on lane 0 and comes back on lane 1. The host supplies a command of up to `MAX_CMD` bytes, states how many response bytes it expects, and pulses `start`. The block then pulls chip select low and shifts the command out with a CRC byte appended. A two-cycle turnaround follows, during which it stops driving lane 0. It then clocks in the response bytes and a trailing CRC byte. At the end it raises chip select again and pulses `done`.

The serial clock is derived from the system clock. Each half period lasts `HALF_CYC` system cycles. Bits are launched on falling edges and sampled on rising edges. The first command bit is put on lane 0 while the clock is still low. The CRC is always generated and always transmitted. The response CRC is compared only after the host has turned checking on. Between transactions the block watches lane 1 and reports the slave pulling it low as an alert.

Top module: `sio_txn_master`

## Requirements
- R1: Command byte 0 leaves first, each byte most significant bit first, followed by exactly one CRC byte. Byte i of `cmd_bytes` sits at bits [8i+7:8i].
- R2: `sclk` is low whenever `cs_n` is high. In the first system cycle after `cs_n` falls, `io0_oe` is 1 and `io0_out` already carries bit 7 of command byte 0, before any rising edge.
- R3: While `sclk` stays high, `io0_out` does not change. New bits appear only after falling edges.
- R4: The CRC byte is CRC-8 with polynomial 0x07 and initial value 0x00, fed most significant bit first over every command byte.
- R5: The two rising edges that follow the command CRC form the turnaround. `io0_oe` is 0 at both of them.
- R6: A transaction has exactly 8*(cmd_len+1) + 2 + 8*(rsp_len+1) rising edges. After the last one `sclk` returns low, `cs_n` rises, and `done` pulses for one cycle.
- R7: Response bits are sampled from `io1_in` on rising edges, most significant bit first. Response byte j is placed in `rsp_bytes[8j+7:8j]`, and bytes at or above `rsp_len` read 0.
- R8: After reset, CRC checking is off and `crc_err` stays 0 even when the received CRC is wrong.
- R9: After a `crc_chk_on` pulse, `crc_err` is 1 after a transaction exactly when the received CRC byte differs from the R4 CRC over the response bytes.
- R10: While idle with `cs_n` high, `io1_in` held low drives `alert` high within `SYNC_STAGES`+1 cycles, and `alert` falls again once `io1_in` returns high. `alert` is never 1 while `cs_n` is low.
- R11: In reset, `cs_n`=1, `sclk`=0, `io0_oe`=0, `busy`=0, `done`=0 and `crc_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| cmd_len | input | $clog2(MAX_CMD+1) | Command bytes before the CRC |
| cmd_bytes | input | 8*MAX_CMD | Command bytes, byte i at [8i+7:8i] |
| rsp_len | input | $clog2(MAX_RSP+1) | Response bytes before the CRC |
| crc_chk_on | input | 1 | Configuration pulse that enables response CRC checking |
| io1_in | input | 1 | Serial lane 1 from slave |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| rsp_bytes | output | 8*MAX_RSP | Received response bytes |
| crc_err | output | 1 | Response CRC mismatch of the last transaction |
| alert | output | 1 | Slave alert seen on lane 1 while deselected |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io0_out | output | 1 | Serial lane 0 data |
| io0_oe | output | 1 | Lane 0 drive enable |

## Verification
The embedded assertions check on every cycle that the clock rests low while chip select is high, that lane 0 holds steady through each high phase, and that lane 0 is released during turnaround. They also check that `crc_err` stays quiet while checking is off and that `alert` never rises under chip select. The bench scenarios are the only place where the content is checked: the command bit order, the CRC values, the exact edge count, the placement of response bytes, and the switch of CRC checking from ignored to enforced. It acts as a slave that captures lane 0 on rising edges and drives lane 1 on falling edges, and it compares the results against values it computes itself.

// File: rtl/sio_txn_pkg.sv
package sio_txn_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_TAR,
      ST_RSP,
      ST_TAIL
   } sio_state_e;

   // One serial CRC step, MSB-first feed
   function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                            input logic       din,
                                            input logic [7:0] poly);
      logic fb;
      fb = crc[7] ^ din;
      return {crc[6:0], 1'b0} ^ (fb ? poly : 8'h00);
   endfunction

endpackage

// File: rtl/sio_sclk_tick.sv
module sio_sclk_tick #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("sio_sclk_tick: HALF_CYC must be at least 1");
      end else if (HALF_CYC == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int TW = $clog2(HALF_CYC);
         localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);
         logic [TW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!run)        cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + TW'(1);
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/sio_crc8.sv
module sio_crc8 #(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       din,
   output logic [7:0] crc
);
   import sio_txn_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= 8'h00;
      else if (clr) crc <= 8'h00;
      else if (en)  crc <= crc8_step(crc, din, POLY);
   end
endmodule

// File: rtl/sio_alert_sync.sv
module sio_alert_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io1_in,
   input  logic idle,
   output logic alert
);
   logic line_s;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sio_alert_sync: SYNC_STAGES must be at least 1");
      end else if (SYNC_STAGES == 1) begin : g_one
         logic s1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1 <= 1'b1;
            else        s1 <= io1_in;
         end
         assign line_s = s1;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2:0], io1_in};
         end
         assign line_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alert <= 1'b0;
      else        alert <= idle && !line_s;
   end
endmodule

// File: rtl/sio_txn_master.sv
module sio_txn_master #(
   parameter int         MAX_CMD     = 8,
   parameter int         MAX_RSP     = 8,
   parameter int         HALF_CYC    = 2,
   parameter int         TAR_CYC     = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CRC_POLY    = 8'h07,
   localparam int        CL_W        = $clog2(MAX_CMD + 1),
   localparam int        RL_W        = $clog2(MAX_RSP + 1),
   localparam int        CMD_W       = 8 * MAX_CMD,
   localparam int        RSP_W       = 8 * MAX_RSP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CL_W-1:0]  cmd_len,
   input  logic [CMD_W-1:0] cmd_bytes,
   input  logic [RL_W-1:0]  rsp_len,
   input  logic             crc_chk_on,
   input  logic             io1_in,
   output logic             busy,
   output logic             done,
   output logic [RSP_W-1:0] rsp_bytes,
   output logic             crc_err,
   output logic             alert,
   output logic             sclk,
   output logic             cs_n,
   output logic             io0_out,
   output logic             io0_oe
);
   import sio_txn_pkg::*;

   localparam int MAXL  = (MAX_CMD > MAX_RSP) ? MAX_CMD : MAX_RSP;
   localparam int CNT_W = $clog2(MAXL * 8 + 16);
   localparam int TW    = $clog2(TAR_CYC + 1);

   generate
      if (MAX_CMD < 2) begin : g_bad_cmd
         $error("sio_txn_master: MAX_CMD must be at least 2");
      end
      if (MAX_RSP < 1) begin : g_bad_rsp
         $error("sio_txn_master: MAX_RSP must be at least 1");
      end
      if (TAR_CYC < 1) begin : g_bad_tar
         $error("sio_txn_master: TAR_CYC must be at least 1");
      end
   endgenerate

   sio_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [TW-1:0]    tar_cnt;
   logic             sclk_q, cs_n_q, done_q, crc_err_q, chk_en;
   logic [CMD_W-1:0] tx_sr, tx_load;
   logic [7:0]       byte_sr;
   logic [RSP_W-1:0] rsp_q;
   logic [CL_W-1:0]  cmd_len_q;
   logic [RL_W-1:0]  rsp_len_q;
   logic [CNT_W-1:0] cmd_bits, rsp_bits, cmd_last, rsp_last;
   logic             tick, crc_en, crc_clr, crc_din;
   logic [7:0]       crc_val;
   logic [7:0]       rx_byte;
   int               rsp_base;
   logic             rsp_store;

   assign cmd_bits = CNT_W'({cmd_len_q, 3'b000});
   assign rsp_bits = CNT_W'({rsp_len_q, 3'b000});
   assign cmd_last = cmd_bits + CNT_W'(7);
   assign rsp_last = rsp_bits + CNT_W'(7);
   assign rx_byte  = {byte_sr[6:0], io1_in};

   // Command bytes reordered so byte 0 bit 7 sits at the top of the shifter
   always_comb begin
      tx_load = '0;
      for (int i = 0; i < MAX_CMD; i++) begin
         tx_load[CMD_W-1-8*i -: 8] = cmd_bytes[8*i +: 8];
      end
   end

   always_comb begin
      rsp_base  = int'(cnt >> 3) * 8;
      rsp_store = (cnt < rsp_bits) && (cnt[2:0] == 3'd7) && (int'(cnt >> 3) < MAX_RSP);
   end

   sio_sclk_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st != ST_IDLE),
      .tick  (tick)
   );

   assign crc_clr = (st == ST_IDLE && start) || (st == ST_TAR);
   assign crc_din = (st == ST_CMD) ? io0_out : io1_in;
   assign crc_en  = tick && !sclk_q &&
                    (((st == ST_CMD) && (cnt < cmd_bits)) ||
                     ((st == ST_RSP) && (cnt < rsp_bits)));

   sio_crc8 #(.POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (crc_din),
      .crc   (crc_val)
   );

   sio_alert_sync #(.SYNC_STAGES(SYNC_STAGES)) u_alert (
      .clk    (clk),
      .rst_n  (rst_n),
      .io1_in (io1_in),
      .idle   (cs_n_q && (st == ST_IDLE) && !start),
      .alert  (alert)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          chk_en <= 1'b0;
      else if (crc_chk_on) chk_en <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         tar_cnt   <= '0;
         sclk_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         done_q    <= 1'b0;
         crc_err_q <= 1'b0;
         tx_sr     <= '0;
         byte_sr   <= '0;
         rsp_q     <= '0;
         cmd_len_q <= '0;
         rsp_len_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st        <= ST_CMD;
                  cs_n_q    <= 1'b0;
                  cnt       <= '0;
                  tx_sr     <= tx_load;
                  cmd_len_q <= cmd_len;
                  rsp_len_q <= rsp_len;
                  rsp_q     <= '0;
                  crc_err_q <= 1'b0;
               end
            end
            ST_CMD: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (cnt == cmd_last) begin
                        st      <= ST_TAR;
                        tar_cnt <= '0;
                        cnt     <= '0;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                        if (cnt + CNT_W'(1) == cmd_bits)
                           tx_sr <= {crc_val, {(CMD_W-8){1'b0}}};
                        else
                           tx_sr <= {tx_sr[CMD_W-2:0], 1'b0};
                     end
                  end
               end
            end
            ST_TAR: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (tar_cnt == TW'(TAR_CYC - 1)) st <= ST_RSP;
                     else tar_cnt <= tar_cnt + TW'(1);
                  end
               end
            end
            ST_RSP: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q  <= 1'b1;
                     byte_sr <= rx_byte;
                     if (rsp_store) rsp_q[rsp_base +: 8] <= rx_byte;
                     if (cnt == rsp_last) crc_err_q <= chk_en && (rx_byte != crc_val);
                  end else begin
                     sclk_q <= 1'b0;
                     if (cnt == rsp_last) st <= ST_TAIL;
                     else cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n_q <= 1'b1;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = done_q;
   assign rsp_bytes = rsp_q;
   assign crc_err   = crc_err_q;
   assign sclk      = sclk_q;
   assign cs_n      = cs_n_q;
   assign io0_out   = tx_sr[CMD_W-1];
   assign io0_oe    = (st == ST_CMD);

   // R2
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R2
   first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (!cs_n && $past(!cs_n)));

   // R3
   io0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk) && io0_oe && $past(io0_oe)) |-> $stable(io0_out));

   // R5
   tar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk) && st == ST_TAR) |-> !io0_oe);

   // R6
   done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !sclk && !busy));

   // R8
   crc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |-> !crc_err);

   // R10
   alert_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !alert);

endmodule

// File: tb/sio_txn_master_test.sv
module sio_txn_master_test;
   localparam int MAX_CMD = 8;
   localparam int MAX_RSP = 8;
   localparam int CL_W    = $clog2(MAX_CMD + 1);
   localparam int RL_W    = $clog2(MAX_RSP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CL_W-1:0] cmd_len = '0;
   logic [8*MAX_CMD-1:0] cmd_bytes = '0;
   logic [RL_W-1:0] rsp_len = '0;
   logic crc_chk_on = 1'b0;
   logic io1 = 1'b1;
   logic busy, done, crc_err, alert, sclk, cs_n, io0, io0_oe;
   logic [8*MAX_RSP-1:0] rsp_bytes;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sio_txn_master #(.MAX_CMD(MAX_CMD), .MAX_RSP(MAX_RSP)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
      .cmd_bytes(cmd_bytes), .rsp_len(rsp_len), .crc_chk_on(crc_chk_on),
      .io1_in(io1), .busy(busy), .done(done), .rsp_bytes(rsp_bytes),
      .crc_err(crc_err), .alert(alert), .sclk(sclk), .cs_n(cs_n),
      .io0_out(io0), .io0_oe(io0_oe));

   // transaction model state
   logic [7:0] tcmd [0:MAX_CMD-1];
   logic [7:0] trsp [0:MAX_RSP];
   int   nc_bits = 0;
   int   nr_bits = 0;
   int   rises   = 0;
   logic cap  [0:127];
   logic rbit [0:127];
   int   tar_oe_hits = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_of(input logic [7:0] b [0:MAX_RSP], input int n);
      logic [7:0] c;
      c = 8'h00;
      for (int i = 0; i < n; i++) begin
         c = c ^ b[i];
         for (int k = 0; k < 8; k++)
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   // slave side: capture on rising edges
   always @(negedge cs_n) begin
      rises = 0;
      tar_oe_hits = 0;
   end

   always @(posedge sclk) begin
      if (rises < 128 && rises < nc_bits) cap[rises] = io0;
      if (rises >= nc_bits && rises < nc_bits + 2 && io0_oe) tar_oe_hits++;
      rises++;
   end

   // slave side: launch on falling edges
   always @(negedge sclk) begin
      int idx;
      idx = rises - (nc_bits + 2);
      if (idx >= 0 && idx < nr_bits) io1 = rbit[idx];
      else io1 = 1'b1;
   end

   // every-clock monitor
   logic prev_sclk = 1'b0;
   logic prev_io0  = 1'b0;
   logic prev_oe   = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         bit ok;
         ok = !(cs_n && sclk) && !(cs_n && io0_oe) && !(!cs_n && alert) &&
              !(sclk && prev_sclk && io0_oe && prev_oe && io0 != prev_io0);
         chk(ok, "R2 R3 R10 cycle", {60'd0, cs_n, sclk, io0, alert}, {60'd0, cs_n, 1'b0, prev_io0, 1'b0});
      end
      prev_sclk = sclk;
      prev_io0  = io0;
      prev_oe   = io0_oe;
   end

   task automatic run_txn(input int nc, input int nr, input bit bad_crc, input bit exp_err);
      logic [7:0] ccrc, rcrc;
      logic [7:0] cbuf [0:MAX_RSP];
      logic [7:0] got;
      for (int i = 0; i <= MAX_RSP; i++) cbuf[i] = 8'h00;
      for (int i = 0; i < nc; i++) cbuf[i] = tcmd[i];
      ccrc = crc_of(cbuf, nc);
      rcrc = crc_of(trsp, nr);
      trsp[nr] = bad_crc ? (rcrc ^ 8'h5A) : rcrc;
      nc_bits = 8 * (nc + 1);
      nr_bits = 8 * (nr + 1);
      for (int k = 0; k < nr_bits; k++) rbit[k] = trsp[k / 8][7 - (k % 8)];
      @(negedge clk);
      cmd_len = CL_W'(nc);
      rsp_len = RL_W'(nr);
      cmd_bytes = '0;
      for (int i = 0; i < nc; i++) cmd_bytes[8*i +: 8] = tcmd[i];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: first bit present while the clock is still low
      chk(!cs_n && !sclk && io0_oe && io0 == tcmd[0][7], "R2 first bit",
          {60'd0, cs_n, sclk, io0_oe, io0}, {60'd0, 1'b0, 1'b0, 1'b1, tcmd[0][7]});
      do @(negedge clk); while (!done);
      // R6
      chk(rises == nc_bits + 2 + nr_bits, "R6 edge count", 64'(rises), 64'(nc_bits + 2 + nr_bits));
      chk(cs_n && !sclk && !busy, "R6 deselect", {61'd0, cs_n, sclk, busy}, 64'h4);
      // R1
      for (int i = 0; i < nc; i++) begin
         got = '0;
         for (int b = 0; b < 8; b++) got[7-b] = cap[8*i + b];
         chk(got == tcmd[i], "R1 command byte", 64'(got), 64'(tcmd[i]));
      end
      // R4
      got = '0;
      for (int b = 0; b < 8; b++) got[7-b] = cap[8*nc + b];
      chk(got == ccrc, "R4 command crc", 64'(got), 64'(ccrc));
      // R5
      chk(tar_oe_hits == 0, "R5 turnaround release", 64'(tar_oe_hits), 64'd0);
      // R7
      for (int j = 0; j < MAX_RSP; j++) begin
         logic [7:0] e;
         e = (j < nr) ? trsp[j] : 8'h00;
         chk(rsp_bytes[8*j +: 8] == e, "R7 response byte", 64'(rsp_bytes[8*j +: 8]), 64'(e));
      end
      // R8 / R9
      chk(crc_err == exp_err, exp_err ? "R9 crc error" : "R8 R9 crc flag", 64'(crc_err), 64'(exp_err));
      @(negedge clk);
      chk(!done, "R6 done pulse width", 64'(done), 64'd0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < MAX_CMD; i++) tcmd[i] = 8'h00;
      for (int i = 0; i <= MAX_RSP; i++) trsp[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R11
      chk(cs_n && !sclk && !io0_oe && !busy && !done && !crc_err, "R11 reset state",
          {58'd0, cs_n, sclk, io0_oe, busy, done, crc_err}, 64'h20);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // A: good crc, checking off
      tcmd[0] = 8'hA5; tcmd[1] = 8'h3C;
      trsp[0] = 8'h81; trsp[1] = 8'h7E; trsp[2] = 8'hC3;
      run_txn(2, 3, 1'b0, 1'b0);

      // B: bad crc, checking still off (R8)
      tcmd[0] = 8'h0F; tcmd[1] = 8'hF0;
      trsp[0] = 8'h12; trsp[1] = 8'h34;
      run_txn(2, 2, 1'b1, 1'b0);

      @(negedge clk);
      crc_chk_on = 1'b1;
      @(negedge clk);
      crc_chk_on = 1'b0;

      // C: good crc, checking on (R9)
      tcmd[0] = 8'h21; tcmd[1] = 8'h00; tcmd[2] = 8'hFF; tcmd[3] = 8'h96;
      trsp[0] = 8'h08;
      run_txn(4, 1, 1'b0, 1'b0);

      // D: bad crc, checking on (R9)
      tcmd[0] = 8'h6B;
      trsp[0] = 8'hDE; trsp[1] = 8'hAD;
      run_txn(1, 2, 1'b1, 1'b1);

      // E: full length, all-zero response keeps io1 low under chip select (R10)
      for (int i = 0; i < MAX_CMD; i++) tcmd[i] = 8'(8'h11 * (i + 1));
      for (int i = 0; i < MAX_RSP; i++) trsp[i] = 8'h00;
      run_txn(MAX_CMD, MAX_RSP, 1'b0, 1'b0);

      // R10: alert while idle
      repeat (6) @(negedge clk);
      chk(!alert, "R10 alert idle high line", 64'(alert), 64'd0);
      io1 = 1'b0;
      repeat (4) @(negedge clk);
      chk(alert, "R10 alert raised", 64'(alert), 64'd1);
      io1 = 1'b1;
      repeat (4) @(negedge clk);
      chk(!alert, "R10 alert cleared", 64'(alert), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule